// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Control

This block is the operand-forwarding control for a five-stage pipeline in which every later stage can feed results back to decode. For each of the two source operands of the instruction in decode, it compares the source register index with the destination indices of the instructions in execute, memory and writeback. It then produces a 2-bit select that picks the register-file value or one of the three forwarded results. Results of jump-and-link, which write the return address to register 31, are forwarded the same way as any other write.

Forwarding covers every dependency except one. A load in execute has no data yet, so the instruction directly behind it must wait. The block raises a stall in that case only. After one stalled cycle the load has reached the memory stage, and its value is forwarded from there.

A small datapath wrapper applies the selects to the incoming stage results. It captures the two chosen operands into registers that feed the execute stage. Those registers hold their value while the stall is high.

Top module: `bypass_ctrl`

## Requirements
- R1: Each operand select is 2 bits wide and uses this code: 0 is the register file, 1 is the execute result, 2 is the memory result and 3 is the writeback result.
- R2: When an operand is read, its index is not 0, the execute-stage instruction writes, and its destination equals that index, the select is 1. This holds whatever the other stages hold.
- R3: When the execute stage does not supply the operand, and the memory-stage instruction writes to the operand's non-zero index, the select is 2.
- R4: When neither execute nor memory supplies the operand, the select is 3 if the writeback-stage instruction writes to the operand's non-zero index. Otherwise the select is 0.
- R5: An operand with index 0 always has select 0, and its captured value is zero whatever the register file supplies.
- R6: An operand whose read-enable is low has select 0 and never causes a stall.
- R7: `stall` is high exactly when the execute opcode equals the load code (parameter, default 6'h23), the execute destination is not 0, and a read-enabled operand index equals that destination. A load in the memory or writeback stage never stalls.
- R8: A synchronous active-high reset clears both operand registers to zero. On a clock edge with `stall` low, each operand register takes the value chosen by its select, with the R5 rule applied.
- R9: On a clock edge with `stall` high, both operand registers keep their previous value.
- R10: A jump-and-link in execute, writing register 31, is forwarded with select 1 to a decode operand that reads register 31. It does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_rs | input | 5 | Decode first source index |
| dec_rt | input | 5 | Decode second source index |
| dec_use_a | input | 1 | First operand is read from a register |
| dec_use_b | input | 1 | Second operand is read from a register |
| ex_dst | input | 5 | Execute-stage destination index |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_op | input | 6 | Execute-stage opcode |
| mem_dst | input | 5 | Memory-stage destination index |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | 5 | Writeback-stage destination index |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| rf_a | input | 32 | Register-file value for the first operand |
| rf_b | input | 32 | Register-file value for the second operand |
| ex_res | input | 32 | Execute-stage result |
| mem_res | input | 32 | Memory-stage result (load data included) |
| wb_res | input | 32 | Writeback-stage result |
| sel_a | output | 2 | First operand select |
| sel_b | output | 2 | Second operand select |
| stall | output | 1 | Load-use interlock |
| opnd_a_q | output | 32 | Captured first operand for execute |
| opnd_b_q | output | 32 | Captured second operand for execute |

## Verification
`sel_a`, `sel_b` and `stall` depend only on the current inputs. They are valid in the same cycle and are compared at the falling edge, after the inputs have settled. The operand registers add one cycle. At each falling edge the bench compares them with the value its model predicted at the previous falling edge, when the inputs were the ones the rising edge captured. When the model expects a stall, the previous register value is carried forward unchanged. A load dependency therefore shows a held register in the stall cycle and a memory-stage forward in the next cycle.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_EX  = 2'd1,
    SRC_MEM = 2'd2,
    SRC_WB  = 2'd3
  } src_e;
endpackage

// File: rtl/bypass_pick.sv
module bypass_pick
  import bypass_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic [RW-1:0] src,
  input  logic          rd_en,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_wen,
  input  logic          ex_is_load,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wen,
  output src_e          sel,
  output logic          load_hit
);
  logic live;
  assign live = rd_en && (src != '0);

  // youngest producer wins
  always_comb begin
    sel = SRC_RF;
    if (live) begin
      if (ex_wen && ex_dst == src)        sel = SRC_EX;
      else if (mem_wen && mem_dst == src) sel = SRC_MEM;
      else if (wb_wen && wb_dst == src)   sel = SRC_WB;
    end
  end

  assign load_hit = live && ex_is_load && (ex_dst == src);
endmodule

// File: rtl/bypass_mux.sv
module bypass_mux
  import bypass_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  src_e            sel,
  input  logic            is_zero,
  input  logic [XLEN-1:0] rf_val,
  input  logic [XLEN-1:0] ex_val,
  input  logic [XLEN-1:0] mem_val,
  input  logic [XLEN-1:0] wb_val,
  output logic [XLEN-1:0] val
);
  always_comb begin
    unique case (sel)
      SRC_EX:  val = ex_val;
      SRC_MEM: val = mem_val;
      SRC_WB:  val = wb_val;
      default: val = rf_val;
    endcase
    if (is_zero) val = '0;
  end
endmodule

// File: rtl/bypass_ctrl.sv
module bypass_ctrl
  import bypass_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter int          NREG    = 32,
  parameter int          OPW     = 6,
  parameter logic [5:0]  LOAD_OP = 6'h23,
  localparam int         RW      = $clog2(NREG),
  localparam int         NSRC    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RW-1:0]   dec_rs,
  input  logic [RW-1:0]   dec_rt,
  input  logic            dec_use_a,
  input  logic            dec_use_b,
  input  logic [RW-1:0]   ex_dst,
  input  logic            ex_wen,
  input  logic [OPW-1:0]  ex_op,
  input  logic [RW-1:0]   mem_dst,
  input  logic            mem_wen,
  input  logic [RW-1:0]   wb_dst,
  input  logic            wb_wen,
  input  logic [XLEN-1:0] rf_a,
  input  logic [XLEN-1:0] rf_b,
  input  logic [XLEN-1:0] ex_res,
  input  logic [XLEN-1:0] mem_res,
  input  logic [XLEN-1:0] wb_res,
  output logic [1:0]      sel_a,
  output logic [1:0]      sel_b,
  output logic            stall,
  output logic [XLEN-1:0] opnd_a_q,
  output logic [XLEN-1:0] opnd_b_q
);
  logic [RW-1:0]   src_idx [NSRC];
  logic            src_en  [NSRC];
  logic [XLEN-1:0] src_rf  [NSRC];
  src_e            src_sel [NSRC];
  logic [XLEN-1:0] src_val [NSRC];
  logic [NSRC-1:0] hit;
  logic            ex_is_load;

  assign src_idx[0] = dec_rs;
  assign src_idx[1] = dec_rt;
  assign src_en[0]  = dec_use_a;
  assign src_en[1]  = dec_use_b;
  assign src_rf[0]  = rf_a;
  assign src_rf[1]  = rf_b;
  assign ex_is_load = (ex_op == LOAD_OP[OPW-1:0]);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    bypass_pick #(.RW(RW)) u_pick (
      .src(src_idx[i]), .rd_en(src_en[i]),
      .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
      .mem_dst(mem_dst), .mem_wen(mem_wen),
      .wb_dst(wb_dst), .wb_wen(wb_wen),
      .sel(src_sel[i]), .load_hit(hit[i])
    );
    bypass_mux #(.XLEN(XLEN)) u_mux (
      .sel(src_sel[i]), .is_zero(src_idx[i] == '0),
      .rf_val(src_rf[i]), .ex_val(ex_res), .mem_val(mem_res),
      .wb_val(wb_res), .val(src_val[i])
    );
  end

  assign sel_a = src_sel[0];
  assign sel_b = src_sel[1];
  assign stall = |hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      opnd_a_q <= '0;
      opnd_b_q <= '0;
    end else if (!stall) begin
      opnd_a_q <= src_val[0];
      opnd_b_q <= src_val[1];
    end
  end
endmodule

// File: rtl/bypass_ctrl_chk.sv
module bypass_ctrl_chk #(
  parameter int         XLEN    = 32,
  parameter int         RW      = 5,
  parameter int         OPW     = 6,
  parameter logic [5:0] LOAD_OP = 6'h23
) (
  input logic            clk,
  input logic            rst,
  input logic [RW-1:0]   dec_rs,
  input logic [RW-1:0]   dec_rt,
  input logic            dec_use_a,
  input logic            dec_use_b,
  input logic [RW-1:0]   ex_dst,
  input logic            ex_wen,
  input logic [OPW-1:0]  ex_op,
  input logic [RW-1:0]   mem_dst,
  input logic            mem_wen,
  input logic [XLEN-1:0] rf_a,
  input logic [1:0]      sel_a,
  input logic [1:0]      sel_b,
  input logic            stall,
  input logic [XLEN-1:0] opnd_a_q,
  input logic [XLEN-1:0] opnd_b_q
);
  a_r2_ex_first: assert property (@(posedge clk) disable iff (rst)
    (dec_use_a && dec_rs != '0 && ex_wen && ex_dst == dec_rs) |-> sel_a == 2'd1);

  a_r3_mem_next: assert property (@(posedge clk) disable iff (rst)
    (dec_use_a && dec_rs != '0 && !(ex_wen && ex_dst == dec_rs)
     && mem_wen && mem_dst == dec_rs) |-> sel_a == 2'd2);

  a_r5_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (dec_rs == '0) |-> sel_a == 2'd0);

  a_r6_unread: assert property (@(posedge clk) disable iff (rst)
    (!dec_use_a && !dec_use_b) |-> (sel_a == 2'd0 && sel_b == 2'd0 && !stall));

  a_r7_load_only: assert property (@(posedge clk) disable iff (rst)
    stall |-> (ex_op == LOAD_OP[OPW-1:0] && ex_dst != '0));

  a_r8_take_rf: assert property (@(posedge clk) disable iff (rst)
    (!stall && sel_a == 2'd0 && dec_rs != '0) |=> opnd_a_q == $past(rf_a));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(opnd_a_q) && $stable(opnd_b_q)));
endmodule

bind bypass_ctrl bypass_ctrl_chk #(
  .XLEN(XLEN), .RW(RW), .OPW(OPW), .LOAD_OP(LOAD_OP)
) u_chk (
  .clk(clk), .rst(rst), .dec_rs(dec_rs), .dec_rt(dec_rt),
  .dec_use_a(dec_use_a), .dec_use_b(dec_use_b),
  .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_op(ex_op),
  .mem_dst(mem_dst), .mem_wen(mem_wen), .rf_a(rf_a),
  .sel_a(sel_a), .sel_b(sel_b), .stall(stall),
  .opnd_a_q(opnd_a_q), .opnd_b_q(opnd_b_q)
);

// File: tb/bypass_ctrl_test.sv
`timescale 1ns/1ps
module bypass_ctrl_test;
  localparam logic [5:0] LD  = 6'h23;
  localparam logic [5:0] ALU = 6'h08;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] dec_rs = '0, dec_rt = '0, ex_dst = '0, mem_dst = '0, wb_dst = '0;
  logic dec_use_a = 1'b0, dec_use_b = 1'b0, ex_wen = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0;
  logic [5:0] ex_op = ALU;
  logic [31:0] rf_a = '0, rf_b = '0, ex_res = '0, mem_res = '0, wb_res = '0;
  logic [1:0] sel_a, sel_b;
  logic stall;
  logic [31:0] opnd_a_q, opnd_b_q;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [31:0] pend_a = '0, pend_b = '0;
  string tag_qa = "R8", tag_qb = "R8";

  always #5 clk = ~clk;

  bypass_ctrl uut (
    .clk(clk), .rst(rst), .dec_rs(dec_rs), .dec_rt(dec_rt),
    .dec_use_a(dec_use_a), .dec_use_b(dec_use_b),
    .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_op(ex_op),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .wb_dst(wb_dst), .wb_wen(wb_wen),
    .rf_a(rf_a), .rf_b(rf_b), .ex_res(ex_res), .mem_res(mem_res), .wb_res(wb_res),
    .sel_a(sel_a), .sel_b(sel_b), .stall(stall),
    .opnd_a_q(opnd_a_q), .opnd_b_q(opnd_b_q)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  // behavioural reference: scan producers youngest first
  task automatic model(input logic [4:0] r, input logic use_r, input logic [31:0] rf,
                       output logic [1:0] s, output logic [31:0] v, output string tag);
    logic [4:0]  dst [3];
    logic        wen [3];
    logic [31:0] res [3];
    dst = '{ex_dst, mem_dst, wb_dst};
    wen = '{ex_wen, mem_wen, wb_wen};
    res = '{ex_res, mem_res, wb_res};
    s = 2'd0; v = rf; tag = "R1/R4";
    if (!use_r) tag = "R6";
    else if (r == 0) tag = "R5";
    else begin
      for (int k = 0; k < 3; k++) begin
        if (s == 2'd0 && wen[k] && dst[k] == r) begin
          s = 2'(k + 1);
          v = res[k];
          tag = (k == 0) ? ((r == 31) ? "R10" : "R1/R2") : (k == 1) ? "R1/R3" : "R1/R4";
        end
      end
    end
    if (r == 0) v = '0;
  endtask

  always @(negedge clk) begin
    logic [1:0] sa, sb;
    logic [31:0] va, vb;
    string ta, tb;
    logic exp_stall;
    if (!done) begin
      cycles++;
      check(tag_qa, opnd_a_q, pend_a);
      check(tag_qb, opnd_b_q, pend_b);
      model(dec_rs, dec_use_a, rf_a, sa, va, ta);
      model(dec_rt, dec_use_b, rf_b, sb, vb, tb);
      exp_stall = (ex_op == LD) && (ex_dst != 0) &&
                  ((dec_use_a && dec_rs == ex_dst) || (dec_use_b && dec_rt == ex_dst));
      check(ta, {30'd0, sel_a}, {30'd0, sa});
      check(tb, {30'd0, sel_b}, {30'd0, sb});
      check(exp_stall ? "R7" : ((ex_dst == 31) ? "R10/R7" : "R7/R6"),
            {31'd0, stall}, {31'd0, exp_stall});
      if (rst) begin
        pend_a = '0; pend_b = '0; tag_qa = "R8"; tag_qb = "R8";
      end else if (exp_stall) begin
        tag_qa = "R9"; tag_qb = "R9";
      end else begin
        pend_a = va; pend_b = vb;
        tag_qa = (dec_rs == 0) ? "R5" : "R8";
        tag_qb = (dec_rt == 0) ? "R5" : "R8";
      end
      if (cycles > 50000) begin
        bad++;
        $display("FAIL watchdog R8 got=%0d exp=%0d", cycles, 50000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  function automatic logic [4:0] pick_reg();
    int x = $urandom_range(0, 5);
    return (x == 5) ? 5'd31 : 5'(x);
  endfunction

  task automatic set(input logic [4:0] rs, rt, input logic ua, ub,
                     input logic [4:0] ed, input logic ew, input logic [5:0] op,
                     input logic [4:0] md, input logic mw, input logic [4:0] wd, input logic ww);
    dec_rs = rs; dec_rt = rt; dec_use_a = ua; dec_use_b = ub;
    ex_dst = ed; ex_wen = ew; ex_op = op;
    mem_dst = md; mem_wen = mw; wb_dst = wd; wb_wen = ww;
    rf_a = $urandom; rf_b = $urandom; ex_res = $urandom; mem_res = $urandom; wb_res = $urandom;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    set(5'd3, 5'd4, 1, 1, 5'd3, 1, ALU, 5'd4, 1, 5'd3, 1);
    repeat (3) step();
    rst = 1'b0;
    // R2 priority over mem and wb; R3 on second operand
    set(5'd3, 5'd4, 1, 1, 5'd3, 1, ALU, 5'd4, 1, 5'd3, 1); step();
    // R4 writeback only; R6 unread operand matching ex
    set(5'd7, 5'd2, 1, 0, 5'd2, 1, ALU, 5'd1, 1, 5'd7, 1); step();
    // R5 register 0 with every stage writing 0
    set(5'd0, 5'd0, 1, 1, 5'd0, 1, LD, 5'd0, 1, 5'd0, 1); step();
    // R10 link value from jump-and-link in execute
    set(5'd31, 5'd5, 1, 1, 5'd31, 1, ALU, 5'd31, 1, 5'd5, 1); step();
    // R7 load-use stall then forward from memory (R3)
    set(5'd6, 5'd1, 1, 1, 5'd6, 1, LD, 5'd0, 0, 5'd0, 0); step();
    set(5'd6, 5'd1, 1, 1, 5'd9, 1, ALU, 5'd6, 1, 5'd0, 0); step();
    // R7 load on rt; R6 load matching unread rs
    set(5'd8, 5'd2, 1, 1, 5'd2, 1, LD, 5'd0, 0, 5'd0, 0); step();
    set(5'd2, 5'd9, 0, 1, 5'd2, 1, LD, 5'd0, 0, 5'd0, 0); step();
    // load in memory stage does not stall
    set(5'd2, 5'd2, 1, 1, 5'd1, 0, ALU, 5'd2, 1, 5'd0, 0); step();
    for (int i = 0; i < 3000; i++) begin
      set(pick_reg(), pick_reg(), 1'($urandom), 1'($urandom), pick_reg(), 1'($urandom),
          ($urandom_range(0, 3) == 0) ? LD : ALU, pick_reg(), 1'($urandom),
          pick_reg(), 1'($urandom));
      if (i == 1500) rst = 1'b1;
      if (i == 1503) rst = 1'b0;
      step();
    end
    @(negedge clk); #1;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule